// File: doc/BRIEF.md
# Data Eye Center and Width Calculator

This block turns the edges of a trained data eye into hardware delay codes, one byte lane at a time. A start pulse captures the left and right edge codes of every lane in signed 1/32 UI units, together with the training direction, the chip select, the write strobe delay of every lane, a minimum eye width, and three scaling settings (low bound, high bound and mask). The block then walks the lanes in ascending order and gives one result per clock cycle with a valid strobe.

For each lane it gives the scaled left and right edges, the scaled eye width, and the scaled center. The center is the delay code to write into that lane's delay register. The block also gives a stored value, which is the center for reads and the center plus the lane's write strobe delay for writes, and the index of the result-table slot. It raises a narrow-eye flag when the scaled width is under the scaled minimum, keeps a run error flag, and keeps a mask of the lanes saved so far.

Top module: `eye_center_calc`

## Requirements
- R1: A code c is scaled to ((lo + c*f) mod 2^8) AND mask, where f = (hi - lo)/32 is a signed division that truncates toward zero and lo, hi are unsigned 8-bit values. Negative results wrap through the mask. The reported left and right edges are the scaled edge codes.
- R2: The reported width is the scaled value of (right - left). The difference is formed one bit wider than the 8-bit signed codes, so it never overflows.
- R3: The reported center is the scaled value of (left + right + 1)/2. The sum is formed wider than the codes, and the division truncates toward zero (left -6, right 2 gives -1).
- R4: The narrow-eye flag is high when the scaled width is smaller than the scaled minimum eye width, using an unsigned compare. The run error flag clears when a start is accepted and goes high with the first narrow lane of the run.
- R5: When direction is 0 (read), the stored value equals the center. When direction is 1 (write), it is (center + that lane's write strobe delay) mod 256.
- R6: The table index is (chip_select / 2) * 9 + lane.
- R7: The block processes 9 lanes (0..8) when ECC lane training is enabled, and 8 lanes (0..7) otherwise. A start sampled at edge E0 gives lane k at edge E(k+1), one lane per cycle. The last lane carries the last flag, and busy drops at that same edge.
- R8: An accepted start clears the saved-lanes mask. Each result sets its lane's bit and forces bits 9 to 15 to 1, so after lane k the mask is 0xFE00 OR (2^(k+1) - 1).
- R9: A start seen while busy is ignored. The lane sequence and every result come from the inputs captured at the accepted start, even if the input ports change during the run.
- R10: After reset, busy, result valid, run error and the saved-lanes mask are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; ignored while busy |
| dir_write | input | 1 | 0 read, 1 write |
| ecc_lane_en | input | 1 | Include the ninth (check) lane |
| cs_sel | input | 3 | Chip select being trained |
| left_codes | input | 72 | Signed left edge codes, lane k at bits 8k+7:8k |
| right_codes | input | 72 | Signed right edge codes, same packing |
| wr_strobe_dly | input | 72 | Write strobe delay per lane, same packing |
| scl_lo | input | 8 | Scaling low bound |
| scl_hi | input | 8 | Scaling high bound |
| scl_mask | input | 8 | Scaling result mask |
| min_eye_code | input | 8 | Signed minimum eye width code |
| busy | output | 1 | Run in progress |
| res_valid | output | 1 | Result fields hold one lane |
| res_last | output | 1 | Final lane of the run |
| res_lane | output | 4 | Lane number of the result |
| res_left | output | 8 | Scaled left edge |
| res_right | output | 8 | Scaled right edge |
| res_width | output | 8 | Scaled eye width |
| res_center | output | 8 | Scaled center, the delay register value |
| res_store | output | 8 | Value to store in the result table |
| res_index | output | 6 | Result table slot |
| res_small | output | 1 | Narrow-eye flag |
| run_err | output | 1 | A narrow lane has been seen in this run |
| saved_lanes | output | 16 | Saved-lanes mask |

## Verification
The lane counter and the captured inputs are the only internal state. A counter that is wrong shows up at once as a skipped or repeated res_lane, as a saved-lanes mask with the wrong bit set, or as busy dropping at the wrong edge, all in the cycle where the error happens. Captured inputs that are wrong, for example overwritten by a start sent during a run, corrupt every later lane of that run. An arithmetic slip shows up only for lanes whose codes reach it: negative sums for rounding, a hi bound below lo for negative factors, and a write strobe delay near 255 for wrap. The stimulus therefore places lanes on each of those cases.

// File: rtl/eye_pkg.sv
package eye_pkg;
   typedef enum logic {
      XFER_READ  = 1'b0,
      XFER_WRITE = 1'b1
   } xfer_dir_e;

   // scaler operand slots inside one lane computation
   localparam int SLOT_LEFT   = 0;
   localparam int SLOT_RIGHT  = 1;
   localparam int SLOT_WIDTH  = 2;
   localparam int SLOT_CENTER = 3;
   localparam int SLOT_MINW   = 4;
   localparam int NUM_SLOTS   = 5;
endpackage

// File: rtl/eye_scaler.sv
module eye_scaler #(
   parameter int IN_W     = 9,
   parameter int DW       = 8,
   parameter int UI_STEPS = 32
) (
   input  logic signed [IN_W-1:0] code,
   input  logic [DW-1:0]          lo,
   input  logic [DW-1:0]          hi,
   input  logic [DW-1:0]          mask,
   output logic [DW-1:0]          reg_code
);
   localparam int PW = IN_W + DW + 2;
   localparam logic signed [DW+1:0] DIVISOR = UI_STEPS[DW+1:0];

   logic signed [DW+1:0] span;
   logic signed [DW+1:0] factor;
   logic [PW-1:0]        prod;
   logic [PW-1:0]        total;

   assign span   = $signed({2'b00, hi}) - $signed({2'b00, lo});
   assign factor = span / DIVISOR;
   assign prod   = {{(PW-IN_W){code[IN_W-1]}}, code} *
                   {{(PW-DW-2){factor[DW+1]}}, factor};
   assign total  = prod + {{(PW-DW){1'b0}}, lo};
   assign reg_code = total[DW-1:0] & mask;
endmodule

// File: rtl/eye_lane_calc.sv
module eye_lane_calc
   import eye_pkg::*;
#(
   parameter int CW       = 8,
   parameter int DW       = 8,
   parameter int UI_STEPS = 32
) (
   input  logic signed [CW-1:0] left,
   input  logic signed [CW-1:0] right,
   input  logic signed [CW-1:0] min_w,
   input  logic [DW-1:0]        lo,
   input  logic [DW-1:0]        hi,
   input  logic [DW-1:0]        mask,
   input  logic [DW-1:0]        wr_dly,
   input  xfer_dir_e            dir,
   output logic [DW-1:0]        left_s,
   output logic [DW-1:0]        right_s,
   output logic [DW-1:0]        width_s,
   output logic [DW-1:0]        center_s,
   output logic [DW-1:0]        store,
   output logic                 narrow
);
   localparam logic signed [CW+1:0] TWO = (CW+2)'(2);

   logic signed [CW:0]   diff;
   logic signed [CW+1:0] sum1;
   logic signed [CW+1:0] half;
   logic signed [CW:0]   sc_in  [NUM_SLOTS];
   logic [DW-1:0]        sc_out [NUM_SLOTS];

   assign diff = {right[CW-1], right} - {left[CW-1], left};
   assign sum1 = {{2{left[CW-1]}}, left} + {{2{right[CW-1]}}, right} + (CW+2)'(1);
   assign half = sum1 / TWO;

   assign sc_in[SLOT_LEFT]   = {left[CW-1], left};
   assign sc_in[SLOT_RIGHT]  = {right[CW-1], right};
   assign sc_in[SLOT_WIDTH]  = diff;
   assign sc_in[SLOT_CENTER] = half[CW:0];
   assign sc_in[SLOT_MINW]   = {min_w[CW-1], min_w};

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_scale
      eye_scaler #(.IN_W(CW+1), .DW(DW), .UI_STEPS(UI_STEPS)) u_sc (
         .code(sc_in[g]), .lo(lo), .hi(hi), .mask(mask), .reg_code(sc_out[g])
      );
   end

   assign left_s   = sc_out[SLOT_LEFT];
   assign right_s  = sc_out[SLOT_RIGHT];
   assign width_s  = sc_out[SLOT_WIDTH];
   assign center_s = sc_out[SLOT_CENTER];
   assign narrow   = sc_out[SLOT_WIDTH] < sc_out[SLOT_MINW];
   assign store    = (dir == XFER_WRITE) ? DW'(sc_out[SLOT_CENTER] + wr_dly)
                                         : sc_out[SLOT_CENTER];
endmodule

// File: rtl/eye_lane_seq.sv
module eye_lane_seq #(
   parameter int MAX_LANES = 9,
   parameter int LANE_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              ecc_en,
   output logic              accept,
   output logic              busy,
   output logic [LANE_W-1:0] lane,
   output logic              last
);
   localparam logic [LANE_W-1:0] TOP_FULL  = LANE_W'(MAX_LANES - 1);
   localparam logic [LANE_W-1:0] TOP_SHORT = LANE_W'(MAX_LANES - 2);

   logic [LANE_W-1:0] top_q;

   assign accept = start & ~busy;
   assign last   = busy & (lane == top_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         lane  <= '0;
         top_q <= '0;
      end else if (accept) begin
         busy  <= 1'b1;
         lane  <= '0;
         top_q <= ecc_en ? TOP_FULL : TOP_SHORT;
      end else if (busy) begin
         if (last) busy <= 1'b0;
         else      lane <= lane + 1'b1;
      end
   end

   // R7
   lane_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last) |=> (busy && lane == $past(lane) + 1'b1));
   // R7
   lane_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (lane == '0));
   // R9
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last && start) |=> (lane != '0));
endmodule

// File: rtl/eye_center_calc.sv
module eye_center_calc
   import eye_pkg::*;
#(
   parameter int MAX_LANES = 9,
   parameter int CW        = 8,
   parameter int DW        = 8,
   parameter int UI_STEPS  = 32,
   parameter int NUM_CS    = 8,
   parameter int TBL_W     = 9,
   parameter int MASK_W    = 16,
   localparam int LANE_W   = $clog2(MAX_LANES),
   localparam int CS_W     = $clog2(NUM_CS),
   localparam int IDX_W    = $clog2((NUM_CS / 2) * TBL_W)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic                    dir_write,
   input  logic                    ecc_lane_en,
   input  logic [CS_W-1:0]         cs_sel,
   input  logic [MAX_LANES*CW-1:0] left_codes,
   input  logic [MAX_LANES*CW-1:0] right_codes,
   input  logic [MAX_LANES*DW-1:0] wr_strobe_dly,
   input  logic [DW-1:0]           scl_lo,
   input  logic [DW-1:0]           scl_hi,
   input  logic [DW-1:0]           scl_mask,
   input  logic [CW-1:0]           min_eye_code,
   output logic                    busy,
   output logic                    res_valid,
   output logic                    res_last,
   output logic [LANE_W-1:0]       res_lane,
   output logic [DW-1:0]           res_left,
   output logic [DW-1:0]           res_right,
   output logic [DW-1:0]           res_width,
   output logic [DW-1:0]           res_center,
   output logic [DW-1:0]           res_store,
   output logic [IDX_W-1:0]        res_index,
   output logic                    res_small,
   output logic                    run_err,
   output logic [MASK_W-1:0]       saved_lanes
);
   if (MAX_LANES < 2 || MAX_LANES >= MASK_W) begin : g_bad_lanes
      $error("MAX_LANES must lie between 2 and MASK_W-1");
   end
   if (UI_STEPS < 1 || UI_STEPS >= (1 << DW)) begin : g_bad_steps
      $error("UI_STEPS must fit the register code width");
   end
   if (TBL_W < MAX_LANES || NUM_CS < 2) begin : g_bad_table
      $error("table width must cover all lanes and NUM_CS must be at least 2");
   end

   localparam logic [MASK_W-1:0] HI_FILL = ~((MASK_W'(1) << MAX_LANES) - MASK_W'(1));

   logic              accept, last;
   logic [LANE_W-1:0] lane;

   xfer_dir_e              dir_q;
   logic [CS_W-1:0]        cs_q;
   logic [MAX_LANES*CW-1:0] left_q, right_q;
   logic [MAX_LANES*DW-1:0] wr_q;
   logic [DW-1:0]          lo_q, hi_q, mask_q;
   logic [CW-1:0]          minw_q;

   logic signed [CW-1:0] left_arr  [MAX_LANES];
   logic signed [CW-1:0] right_arr [MAX_LANES];
   logic [DW-1:0]        wr_arr    [MAX_LANES];

   logic [DW-1:0]    c_left, c_right, c_width, c_center, c_store;
   logic             c_narrow;
   logic [IDX_W-1:0] c_index;

   eye_lane_seq #(.MAX_LANES(MAX_LANES), .LANE_W(LANE_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .ecc_en(ecc_lane_en),
      .accept(accept), .busy(busy), .lane(lane), .last(last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= XFER_READ;
         cs_q   <= '0;
         left_q <= '0;
         right_q <= '0;
         wr_q   <= '0;
         lo_q   <= '0;
         hi_q   <= '0;
         mask_q <= '0;
         minw_q <= '0;
      end else if (accept) begin
         dir_q  <= xfer_dir_e'(dir_write);
         cs_q   <= cs_sel;
         left_q <= left_codes;
         right_q <= right_codes;
         wr_q   <= wr_strobe_dly;
         lo_q   <= scl_lo;
         hi_q   <= scl_hi;
         mask_q <= scl_mask;
         minw_q <= min_eye_code;
      end
   end

   for (genvar g = 0; g < MAX_LANES; g++) begin : g_unpack
      assign left_arr[g]  = left_q[g*CW +: CW];
      assign right_arr[g] = right_q[g*CW +: CW];
      assign wr_arr[g]    = wr_q[g*DW +: DW];
   end

   eye_lane_calc #(.CW(CW), .DW(DW), .UI_STEPS(UI_STEPS)) u_calc (
      .left(left_arr[lane]), .right(right_arr[lane]), .min_w(minw_q),
      .lo(lo_q), .hi(hi_q), .mask(mask_q), .wr_dly(wr_arr[lane]), .dir(dir_q),
      .left_s(c_left), .right_s(c_right), .width_s(c_width),
      .center_s(c_center), .store(c_store), .narrow(c_narrow)
   );

   assign c_index = IDX_W'(32'(cs_q >> 1) * TBL_W + 32'(lane));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid   <= 1'b0;
         res_last    <= 1'b0;
         res_lane    <= '0;
         res_left    <= '0;
         res_right   <= '0;
         res_width   <= '0;
         res_center  <= '0;
         res_store   <= '0;
         res_index   <= '0;
         res_small   <= 1'b0;
         run_err     <= 1'b0;
         saved_lanes <= '0;
      end else begin
         res_valid <= busy;
         res_last  <= last;
         if (accept) begin
            run_err     <= 1'b0;
            saved_lanes <= '0;
         end else if (busy) begin
            res_lane    <= lane;
            res_left    <= c_left;
            res_right   <= c_right;
            res_width   <= c_width;
            res_center  <= c_center;
            res_store   <= c_store;
            res_index   <= c_index;
            res_small   <= c_narrow;
            run_err     <= run_err | c_narrow;
            saved_lanes <= saved_lanes | (MASK_W'(1) << lane) | HI_FILL;
         end
      end
   end

   // R8
   saved_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (saved_lanes[res_lane] && (&saved_lanes[MASK_W-1:MAX_LANES])));
   // R4
   err_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_small) |-> run_err);
   // R5
   read_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && dir_q == XFER_READ) |-> (res_store == res_center));
   // R7
   last_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_last) |-> !busy);
   // R6
   index_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_index >= IDX_W'(res_lane)));
endmodule

// File: tb/tb_eye_center_calc.sv
`timescale 1ns/1ps
module tb_eye_center_calc;
   typedef struct packed {
      logic       dir;
      logic       ecc;
      logic [2:0] cs;
      logic [7:0] lo, hi, mask;
      int         minw, lbase, lstep, rbase, rstep, wbase;
   } row_t;

   localparam int NROWS = 4;
   localparam row_t ROWS [NROWS] = '{
      '{1'b0, 1'b1, 3'd0, 8'd0,   8'd64,  8'hFF, 6, -8,  1, 10, -1, 0},
      '{1'b1, 1'b0, 3'd3, 8'd4,   8'd100, 8'h7F, 2, -5,  2,  2,  3, 10},
      '{1'b0, 1'b1, 3'd7, 8'd10,  8'd8,   8'h3F, 0, -6,  1,  2,  0, 0},
      '{1'b1, 1'b1, 3'd5, 8'd200, 8'd40,  8'hFF, 4, -3, -1,  6,  0, 250}
   };

   logic clk = 0, rst_n = 0, start = 0, dir_write = 0, ecc_lane_en = 0;
   logic [2:0]  cs_sel = 0;
   logic [71:0] left_codes = 0, right_codes = 0, wr_strobe_dly = 0;
   logic [7:0]  scl_lo = 0, scl_hi = 0, scl_mask = 0, min_eye_code = 0;
   logic busy, res_valid, res_last, res_small, run_err;
   logic [3:0]  res_lane;
   logic [7:0]  res_left, res_right, res_width, res_center, res_store;
   logic [5:0]  res_index;
   logic [15:0] saved_lanes;

   int checks = 0, errors = 0;

   always #2 clk = ~clk;

   eye_center_calc dut (.*);

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int scl(row_t r, int code);
      int f = (int'(r.hi) - int'(r.lo)) / 32;
      return (int'(r.lo) + code * f) & int'(r.mask) & 255;
   endfunction

   task automatic run_row(row_t r, bit poke);
      int n = r.ecc ? 9 : 8;
      int err = 0;
      @(negedge clk);
      dir_write = r.dir; ecc_lane_en = r.ecc; cs_sel = r.cs;
      scl_lo = r.lo; scl_hi = r.hi; scl_mask = r.mask; min_eye_code = 8'(r.minw);
      for (int k = 0; k < 9; k++) begin
         left_codes[k*8 +: 8]    = 8'(r.lbase + k*r.lstep);
         right_codes[k*8 +: 8]   = 8'(r.rbase + k*r.rstep);
         wr_strobe_dly[k*8 +: 8] = 8'(r.wbase + 5*k);
      end
      start = 1;
      @(negedge clk);
      start = 0;
      for (int k = 0; k < n; k++) begin
         int l = r.lbase + k*r.lstep;
         int rr = r.rbase + k*r.rstep;
         int cen = scl(r, (l + rr + 1) / 2);
         int wid = scl(r, rr - l);
         int sm = (wid < scl(r, r.minw)) ? 1 : 0;
         int st = r.dir ? ((cen + r.wbase + 5*k) & 255) : cen;
         if (poke && k == 3) begin
            start = 1; left_codes = '0; right_codes = '1; ecc_lane_en = 0;
         end
         @(negedge clk);
         start = 0;
         err = err | sm;
         chk("R7 valid", res_valid, 1);
         chk("R7 lane", res_lane, k);
         chk("R7 last", res_last, (k == n-1) ? 1 : 0);
         chk("R7 busy", busy, (k == n-1) ? 0 : 1);
         chk("R1 left", res_left, scl(r, l));
         chk("R1 right", res_right, scl(r, rr));
         chk("R2 width", res_width, wid);
         chk("R3 center", res_center, cen);
         chk("R5 store", res_store, st);
         chk("R6 index", res_index, (r.cs / 2) * 9 + k);
         chk("R4 small", res_small, sm);
         chk("R4 err", run_err, err);
         chk("R8 saved", saved_lanes, 16'hFE00 | ((1 << (k+1)) - 1));
         if (poke) chk("R9 poke", res_lane, k);
      end
      @(negedge clk);
      chk("R7 idle valid", res_valid, 0);
      chk("R7 idle busy", busy, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1;
      // R10 reset state
      chk("R10 busy", busy, 0);
      chk("R10 valid", res_valid, 0);
      chk("R10 err", run_err, 0);
      chk("R10 saved", saved_lanes, 0);
      repeat (3) @(negedge clk);
      rst_n = 1;
      for (int i = 0; i < NROWS; i++) run_row(ROWS[i], 1'b0);
      // R9: start and input changes during a run are ignored
      run_row(ROWS[0], 1'b1);
      // R4: error flag cleared by the next accepted start
      run_row(ROWS[1], 1'b0);
      // R3: rounding toward zero on a negative sum
      run_row('{1'b0, 1'b1, 3'd1, 8'd0, 8'd32, 8'hFF, 0, -6, 0, 2, 0, 0}, 1'b0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule